// File: doc/BRIEF.md
# Atomic Synchronization Memory Unit

This block is a small word-addressed memory that sits on the memory side of several requesters and carries out indivisible read-modify-write operations on their behalf. Alongside ordinary load and store it offers three synchronization primitives: swap, test-and-set and fetch-and-increment. Every operation hands the word's prior content back to the requester. A lock routine depends on that returned value to decide whether it acquired the lock or has to try again.

Each requester port presents an operation code, a word address and a data word, and holds its request line until the acknowledge pulse comes back. A rotating-priority arbiter admits one port per clock. The read of the addressed word and the write of its new value both happen in that single admitted slot, so no other port can reach the word between them. A lock word holds 0 when it is free and 1 when it is taken. A waiter can poll with plain loads and issue test-and-set or swap only after it has seen 0.

Top module: `atomic_sync_mem`

## Requirements
- R1: After reset every acknowledge is low, every returned-data output is zero and every memory word reads as zero.
- R2: At most one port is acknowledged per cycle. An acknowledge is a one-cycle pulse that comes on the clock after a cycle in which that port's request was high and it was selected. A port is never selected in the cycle where its own acknowledge is high.
- R3: Selection rotates. The search for the next port to serve begins at the port after the one served last, so a port that keeps its request high waits for no more than NPORTS-1 other grants.
- R4: Code 0 (load) returns the addressed word and leaves it unchanged.
- R5: Code 1 (store) writes the request data to the word and returns the previous value.
- R6: Code 2 (swap) writes the request data to the word and returns the previous value, as a single step, so that swapping in 1 on a lock word acquires the lock exactly when 0 comes back.
- R7: Code 3 (test-and-set) writes 1 when the word is zero and leaves a nonzero word unchanged. In both cases it returns the old value.
- R8: Code 4 (fetch-and-increment) returns the word and stores the word plus one, modulo 2^DW, so the all-ones value wraps to zero.
- R9: Codes 5, 6 and 7 behave as loads. They return the word and write nothing.
- R10: The returned data of a port changes only in the cycle its acknowledge is high. Because read and write share a single grant slot, a spin lock built from loads, test-and-set or swap, and a releasing store never admits two holders at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NPORTS | Request line per port, held until acknowledged |
| op | input | 3*NPORTS | Operation code per port (3 bits each) |
| addr | input | AW*NPORTS | Word address per port |
| wdata | input | DW*NPORTS | Data word per port |
| ack | output | NPORTS | One-cycle acknowledge per port |
| rdata | output | DW*NPORTS | Previous word value returned to each port, valid with ack |

## Verification
The embedded properties assume that requesters follow the handshake: a port keeps its operation, address and data stable from the moment it raises its request until its acknowledge arrives, and it keeps the request low during reset. Every requester task in the bench changes these inputs only right after a clock edge, and only before raising the request or after it has seen the acknowledge. Reset is applied with all request lines low. The reference model in the bench predicts the grant order and returned values every cycle from the port inputs alone, so it does not depend on those assumptions holding.

// File: rtl/atomic_sync_mem.sv
module atomic_sync_mem #(
  parameter int NPORTS = 4,
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORTS-1:0]   req,
  input  logic [3*NPORTS-1:0] op,
  input  logic [AW*NPORTS-1:0] addr,
  input  logic [DW*NPORTS-1:0] wdata,
  output logic [NPORTS-1:0]   ack,
  output logic [DW*NPORTS-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam logic [2:0] OP_LOAD = 3'd0;
  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_SWAP = 3'd2;
  localparam logic [2:0] OP_TAS = 3'd3;
  localparam logic [2:0] OP_FINC = 3'd4;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr;
  logic [NPORTS-1:0] elig;
  logic [PW-1:0] gidx;
  logic fire;
  logic [2:0] gop;
  logic [AW-1:0] gaddr;
  logic [DW-1:0] gwd, old, nxt;
  logic wr;

  assign elig = req & ~ack;

  always_comb begin
    fire = 1'b0;
    gidx = '0;
    for (int k = 0; k < NPORTS; k++) begin
      int c;
      c = int'(ptr) + k;
      if (c >= NPORTS) c = c - NPORTS;
      if (!fire && elig[c]) begin
        fire = 1'b1;
        gidx = PW'(c);
      end
    end
  end

  assign gop   = op[3*gidx +: 3];
  assign gaddr = addr[AW*gidx +: AW];
  assign gwd   = wdata[DW*gidx +: DW];
  assign old   = mem[gaddr];

  always_comb begin
    wr  = 1'b0;
    nxt = old;
    case (gop)
      OP_STORE, OP_SWAP: begin wr = 1'b1; nxt = gwd; end
      OP_TAS:  begin wr = (old == '0); nxt = DW'(1); end
      OP_FINC: begin wr = 1'b1; nxt = old + DW'(1); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (fire && wr) begin
      mem[gaddr] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack   <= '0;
      rdata <= '0;
      ptr   <= '0;
    end else begin
      ack <= fire ? (NPORTS'(1) << gidx) : '0;
      if (fire) begin
        rdata[DW*gidx +: DW] <= old;
        ptr <= (int'(gidx) == NPORTS-1) ? '0 : gidx + PW'(1);
      end
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ack)); // R2
  AST_ACK_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0) |-> (($past(req) & ack) == ack)); // R2
  AST_SWAP_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fire) && $past(gop) == OP_SWAP) |-> mem[$past(gaddr)] == $past(gwd)); // R6
  AST_TAS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fire) && $past(gop) == OP_TAS) |->
      mem[$past(gaddr)] == (($past(old) == '0) ? DW'(1) : $past(old))); // R7
  AST_FINC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fire) && $past(gop) == OP_FINC) |->
      mem[$past(gaddr)] == DW'($past(old) + DW'(1))); // R8
  AST_NOOP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fire) && $past(gop) > OP_FINC) |-> mem[$past(gaddr)] == $past(old)); // R9

  for (genvar i = 0; i < NPORTS; i++) begin : g_port_chk
    AST_RDATA_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ack[i]) |-> rdata[DW*i +: DW] == $past(old)); // R4
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !ack[i]) |-> $stable(rdata[DW*i +: DW])); // R10
  end
endmodule

// File: tb/atomic_sync_mem_bench.sv
module atomic_sync_mem_bench;
  localparam int NP = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int ROUNDS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_b [NP];
  logic [2:0] op_b [NP];
  logic [AW-1:0] addr_b [NP];
  logic [DW-1:0] wd_b [NP];
  logic [NP-1:0] req;
  logic [3*NP-1:0] op;
  logic [AW*NP-1:0] addr;
  logic [DW*NP-1:0] wdata;
  logic [NP-1:0] ack;
  logic [DW*NP-1:0] rdata;

  int tests = 0, fails = 0, cyc = 0, owners = 0, done = 0;
  int ack_time [NP];

  always #4 clk = ~clk;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      req[p] = req_b[p];
      op[3*p +: 3] = op_b[p];
      addr[AW*p +: AW] = addr_b[p];
      wdata[DW*p +: DW] = wd_b[p];
    end
  end

  atomic_sync_mem #(.NPORTS(NP), .AW(AW), .DW(DW)) u_atomic_sync_mem (
    .clk(clk), .rst_n(rst_n), .req(req), .op(op), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(rdata));

  // behavioural reference model
  int m_mem [1 << AW];
  int m_ptr;
  logic [NP-1:0] x_ack;
  int x_rd [NP];

  always @(negedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_ptr = 0; x_ack = '0;
      foreach (x_rd[i]) x_rd[i] = 0;
    end else begin
      tests++;
      if (ack !== x_ack) begin
        fails++;
        $display("FAIL R2 R3 ack order: got %b expected %b", ack, x_ack);
      end
      for (int p = 0; p < NP; p++) begin
        tests++;
        if (int'(rdata[DW*p +: DW]) != x_rd[p]) begin
          fails++;
          $display("FAIL R4 R10 port %0d rdata: got %h expected %h", p, rdata[DW*p +: DW], x_rd[p]);
        end
      end
      begin
        int g; int a; int o; logic [NP-1:0] na;
        g = -1; na = '0;
        for (int k = 0; k < NP; k++) begin
          int c; c = (m_ptr + k) % NP;
          if (g < 0 && req[c] && !x_ack[c]) g = c;
        end
        if (g >= 0) begin
          a = int'(addr_b[g]); o = m_mem[a];
          case (op_b[g])
            3'd1, 3'd2: m_mem[a] = int'(wd_b[g]);
            3'd3: if (o == 0) m_mem[a] = 1;
            3'd4: m_mem[a] = (o + 1) % (1 << DW);
            default: ;
          endcase
          x_rd[g] = o; na[g] = 1'b1; m_ptr = (g + 1) % NP;
        end
        x_ack = na;
      end
    end
  end

  task automatic xact(input int p, input logic [2:0] o, input int a, input int d, output int rd);
    @(posedge clk); #1;
    req_b[p] = 1'b1; op_b[p] = o; addr_b[p] = AW'(a); wd_b[p] = DW'(d);
    do begin @(posedge clk); #1; end while (!ack[p]);
    rd = int'(rdata[DW*p +: DW]);
    ack_time[p] = cyc;
    req_b[p] = 1'b0;
  endtask

  task automatic expect_eq(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic worker(input int p);
    int rd;
    for (int n = 0; n < ROUNDS; n++) begin
      int got;
      got = 0;
      while (!got) begin
        xact(p, 3'd0, 0, 0, rd);
        if (rd == 0) begin
          xact(p, (p % 2) ? 3'd2 : 3'd3, 0, 1, rd);
          if (rd == 0) got = 1;
        end
      end
      owners++;
      expect_eq("R10 single lock holder", owners, 1);
      xact(p, 3'd4, 1, 0, rd);
      owners--;
      xact(p, 3'd1, 0, 0, rd);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int rd;
    for (int p = 0; p < NP; p++) begin
      req_b[p] = 1'b0; op_b[p] = '0; addr_b[p] = '0; wd_b[p] = '0;
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_eq("R1 ack after reset", int'(ack), 0);
    expect_eq("R1 rdata after reset", (rdata == '0) ? 0 : 1, 0);

    xact(0, 3'd0, 4, 0, rd);      expect_eq("R1 memory cleared", rd, 0);
    xact(0, 3'd1, 4, 16'hFFFF, rd); expect_eq("R5 store returns old", rd, 0);
    xact(0, 3'd4, 4, 0, rd);      expect_eq("R8 increment returns old", rd, 16'hFFFF);
    xact(0, 3'd0, 4, 0, rd);      expect_eq("R8 wrap to zero", rd, 0);
    xact(1, 3'd1, 5, 5, rd);
    xact(1, 3'd3, 5, 0, rd);      expect_eq("R7 tas on busy word", rd, 5);
    xact(1, 3'd0, 5, 0, rd);      expect_eq("R7 busy word kept", rd, 5);
    xact(2, 3'd3, 6, 0, rd);      expect_eq("R7 tas on free word", rd, 0);
    xact(2, 3'd0, 6, 0, rd);      expect_eq("R7 free word set", rd, 1);
    xact(3, 3'd2, 7, 16'hABCD, rd); expect_eq("R6 swap returns old", rd, 0);
    xact(3, 3'd6, 7, 16'h1234, rd); expect_eq("R9 unused code returns word", rd, 16'hABCD);
    xact(3, 3'd0, 7, 0, rd);      expect_eq("R4 load after unused code", rd, 16'hABCD);

    for (int p = 0; p < NP; p++) begin
      automatic int q = p;
      fork begin int r; xact(q, 3'd4, 8, 0, r); end join_none
    end
    wait fork;
    begin
      int lo, hi;
      lo = ack_time[0]; hi = ack_time[0];
      for (int p = 1; p < NP; p++) begin
        if (ack_time[p] < lo) lo = ack_time[p];
        if (ack_time[p] > hi) hi = ack_time[p];
      end
      expect_eq("R3 all ports served in NP cycles", hi - lo, NP - 1);
    end
    xact(0, 3'd0, 8, 0, rd); expect_eq("R8 shared counter", rd, NP);

    for (int p = 0; p < NP; p++) begin
      automatic int q = p;
      fork worker(q); join_none
    end
    wait fork;
    xact(0, 3'd0, 1, 0, rd); expect_eq("R10 critical sections counted", rd, NP * ROUNDS);
    xact(0, 3'd0, 0, 0, rd); expect_eq("R10 lock released", rd, 0);

    repeat (3) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule